// File: doc/BRIEF.md
# Four-Slot In-Order Retirement Buffer

This block keeps the program order of in-flight instructions in a speculative out-of-order core. Each issued instruction claims one of four slots, numbered 0 to 3, in circular order. The slot stores the destination register tag, the instruction class, a completion flag and, for ALU instructions, the result value. ALU results arrive on a single result-broadcast bus that is addressed by slot number. Stores and branches never use that bus. They are marked complete through a separate completion port, and a branch also reports there whether it was mispredicted.

Only the oldest slot can retire, and at most one slot retires per cycle. The retire port shows the slot number, destination tag, value and class for exactly the cycle in which the slot retires, so the rename table and the memory side can act on it. When a mispredicted branch retires, every younger slot is discarded and a flush output is high in that same cycle. The next issue then goes to the slot that follows the branch. When all four slots are occupied, issue is refused unless the oldest slot retires in that cycle. In that case the freed slot is handed straight to the new instruction.

Top module: `spec_retire_buffer`

## Requirements
- R1: After reset the buffer is empty: issue_ready_o is 1, retire_valid_o and flush_o are 0, and issue_idx_o is 0. Accepted issues receive slot numbers 0, 1, 2, 3, 0, ... in circular order, and issue_idx_o always shows the slot that the next accepted issue will receive.
- R2: At most one slot retires per cycle, and it is always the oldest occupied slot. retire_idx_o advances by one, modulo 4, between successive retirements unless a flush intervenes.
- R3: A completed slot does not retire while any older slot is still incomplete.
- R4: With four slots occupied and no retirement in the current cycle, issue_ready_o is 0 and the issue is not taken.
- R5: An ALU slot (class 0) whose value appears on the result bus (wb_valid_i, wb_idx_i, wb_data_i) in cycle t can retire no earlier than cycle t+1. Its retire port then shows its slot number, destination tag and that value.
- R6: A store (class 1) or branch (class 2) slot becomes complete through done_valid_i/done_idx_i in cycle t and can retire from cycle t+1, with no result-bus write. retire_class_o shows its class.
- R7: With four slots occupied and the oldest slot retiring in the current cycle, issue_ready_o is 1 and the issue takes the slot being freed.
- R8: When a branch whose completion was reported with done_mispred_i=1 retires, flush_o is 1 in that cycle, issue_ready_o is 0 in that cycle, every younger slot is discarded without retiring, and the next accepted issue receives the slot after the branch.
- R9: Result-bus writes to an unoccupied slot or to a store or branch slot are ignored, and completion reports for ALU slots are ignored. A store or branch retires with value 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request for a new instruction |
| issue_class_i | input | 2 | Class: 0 ALU, 1 store, 2 branch |
| issue_dest_i | input | 5 | Destination register tag |
| issue_ready_o | output | 1 | Issue is accepted in this cycle |
| issue_idx_o | output | 2 | Slot that the next accepted issue receives |
| wb_valid_i | input | 1 | Result-bus write is valid |
| wb_idx_i | input | 2 | Slot addressed by the result bus |
| wb_data_i | input | 32 | Result value |
| done_valid_i | input | 1 | Store or branch completion is valid |
| done_idx_i | input | 2 | Slot that completed |
| done_mispred_i | input | 1 | The completed branch was mispredicted |
| retire_valid_o | output | 1 | A slot retires in this cycle |
| retire_idx_o | output | 2 | Retiring slot number |
| retire_dest_o | output | 5 | Destination tag of the retiring slot |
| retire_value_o | output | 32 | Value of the retiring slot |
| retire_class_o | output | 2 | Class of the retiring slot |
| flush_o | output | 1 | Younger slots discarded in this cycle |

## Verification
A wrong head pointer shows at the retire port in the first retiring cycle after the error, as a wrong slot number, tag or value. A wrong tail pointer shows at once on issue_idx_o. A wrong occupancy count shows as issue_ready_o taking the wrong value once the buffer reaches four slots, or as the pointer gap check failing in the next cycle. A missed or stale completion flag shows as a retirement that comes one cycle too early, comes too late, or never comes. The bench compares every port in every cycle with an independent model, so each of these errors is reported in the cycle where it first reaches a port.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [1:0] {
    CLS_ALU    = 2'd0,
    CLS_STORE  = 2'd1,
    CLS_BRANCH = 2'd2
  } op_class_e;
endpackage

// File: rtl/srb_ptrs.sv
module srb_ptrs #(
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             retire_i,
  input  logic             flush_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  // DEPTH is a power of two, so the pointers wrap naturally
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      head_q  <= head_q + IDX_W'(1);
      tail_q  <= head_q + IDX_W'(1);
      count_q <= '0;
    end else begin
      head_q  <= head_q + IDX_W'(retire_i);
      tail_q  <= tail_q + IDX_W'(alloc_i);
      count_q <= count_q + CNT_W'(alloc_i) - CNT_W'(retire_i);
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  a_r7_full_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CNT_W'(DEPTH) && alloc_i) |-> retire_i);
  a_r8_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0 && head_q == tail_q));
  a_r1_ptr_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_q - head_q) == count_q[IDX_W-1:0]);
endmodule

// File: rtl/srb_entries.sv
module srb_entries
  import srb_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  op_class_e         alloc_cls_i,
  input  logic [TAG_W-1:0]  alloc_dest_i,
  input  logic              wb_valid_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              done_valid_i,
  input  logic [IDX_W-1:0]  done_idx_i,
  input  logic              done_mispred_i,
  input  logic              retire_i,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  head_i,
  output logic              head_valid_o,
  output logic              head_ready_o,
  output op_class_e         head_cls_o,
  output logic [TAG_W-1:0]  head_dest_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              head_mispred_o
);
  logic [DEPTH-1:0] valid_vec, ready_vec, misp_vec;
  op_class_e         cls_arr  [DEPTH];
  logic [TAG_W-1:0]  dest_arr [DEPTH];
  logic [DATA_W-1:0] data_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              valid_q, ready_q, misp_q;
    op_class_e         cls_q;
    logic [TAG_W-1:0]  dest_q;
    logic [DATA_W-1:0] data_q;
    logic wb_hit, done_hit, alloc_hit, free_hit;

    assign wb_hit    = wb_valid_i && wb_idx_i == IDX_W'(g) && valid_q
                       && cls_q == CLS_ALU && !ready_q;
    assign done_hit  = done_valid_i && done_idx_i == IDX_W'(g) && valid_q
                       && cls_q != CLS_ALU && !ready_q;
    assign alloc_hit = alloc_i && alloc_idx_i == IDX_W'(g);
    assign free_hit  = flush_i || (retire_i && head_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        ready_q <= 1'b0;
        misp_q  <= 1'b0;
        cls_q   <= CLS_ALU;
        dest_q  <= '0;
        data_q  <= '0;
      end else begin
        if (wb_hit) begin
          data_q  <= wb_data_i;
          ready_q <= 1'b1;
        end
        if (done_hit) begin
          ready_q <= 1'b1;
          misp_q  <= done_mispred_i && cls_q == CLS_BRANCH;
        end
        if (free_hit) valid_q <= 1'b0;
        // allocation into a slot freed this cycle wins
        if (alloc_hit) begin
          valid_q <= 1'b1;
          ready_q <= 1'b0;
          misp_q  <= 1'b0;
          cls_q   <= alloc_cls_i;
          dest_q  <= alloc_dest_i;
          data_q  <= '0;
        end
      end
    end

    assign valid_vec[g] = valid_q;
    assign ready_vec[g] = ready_q;
    assign misp_vec[g]  = misp_q;
    assign cls_arr[g]   = cls_q;
    assign dest_arr[g]  = dest_q;
    assign data_arr[g]  = data_q;
  end

  assign head_valid_o   = valid_vec[head_i];
  assign head_ready_o   = ready_vec[head_i];
  assign head_cls_o     = cls_arr[head_i];
  assign head_dest_o    = dest_arr[head_i];
  assign head_data_o    = data_arr[head_i];
  assign head_mispred_o = misp_vec[head_i];

  a_r5_wb_sets_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && valid_vec[wb_idx_i] && cls_arr[wb_idx_i] == CLS_ALU
     && !flush_i && !(alloc_i && alloc_idx_i == wb_idx_i))
    |=> ready_vec[$past(wb_idx_i)]);
  a_r9_wb_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && valid_vec[wb_idx_i] && cls_arr[wb_idx_i] != CLS_ALU
     && !(alloc_i && alloc_idx_i == wb_idx_i))
    |=> data_arr[$past(wb_idx_i)] == $past(data_arr[wb_idx_i]));
endmodule

// File: rtl/spec_retire_buffer.sv
module spec_retire_buffer
  import srb_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [1:0]        issue_class_i,
  input  logic [TAG_W-1:0]  issue_dest_i,
  output logic              issue_ready_o,
  output logic [IDX_W-1:0]  issue_idx_o,
  input  logic              wb_valid_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              done_valid_i,
  input  logic [IDX_W-1:0]  done_idx_i,
  input  logic              done_mispred_i,
  output logic              retire_valid_o,
  output logic [IDX_W-1:0]  retire_idx_o,
  output logic [TAG_W-1:0]  retire_dest_o,
  output logic [DATA_W-1:0] retire_value_o,
  output logic [1:0]        retire_class_o,
  output logic              flush_o
);
  logic [IDX_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              head_valid, head_ready, head_misp;
  op_class_e         head_cls;
  logic [TAG_W-1:0]  head_dest;
  logic [DATA_W-1:0] head_data;
  logic              retire, flush, alloc;

  assign retire = head_valid && head_ready;
  assign flush  = retire && head_cls == CLS_BRANCH && head_misp;
  assign issue_ready_o = (count < CNT_W'(DEPTH) || retire) && !flush;
  assign alloc  = issue_valid_i && issue_ready_o;

  srb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alloc_i  (alloc),
    .retire_i (retire),
    .flush_i  (flush),
    .head_o   (head),
    .tail_o   (tail),
    .count_o  (count)
  );

  srb_entries #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_entries (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .alloc_i        (alloc),
    .alloc_idx_i    (tail),
    .alloc_cls_i    (op_class_e'(issue_class_i)),
    .alloc_dest_i   (issue_dest_i),
    .wb_valid_i     (wb_valid_i),
    .wb_idx_i       (wb_idx_i),
    .wb_data_i      (wb_data_i),
    .done_valid_i   (done_valid_i),
    .done_idx_i     (done_idx_i),
    .done_mispred_i (done_mispred_i),
    .retire_i       (retire),
    .flush_i        (flush),
    .head_i         (head),
    .head_valid_o   (head_valid),
    .head_ready_o   (head_ready),
    .head_cls_o     (head_cls),
    .head_dest_o    (head_dest),
    .head_data_o    (head_data),
    .head_mispred_o (head_misp)
  );

  assign issue_idx_o    = tail;
  assign retire_valid_o = retire;
  assign retire_idx_o   = head;
  assign retire_dest_o  = head_dest;
  assign retire_value_o = head_data;
  assign retire_class_o = head_cls;
  assign flush_o        = flush;

  a_r8_flush_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (retire_valid_o && retire_class_o == 2'd2 && !issue_ready_o));
  a_r2_head_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_valid_o && !flush_o) |=> (count == '0 || !retire_valid_o
      || retire_idx_o == $past(retire_idx_o) + IDX_W'(1)));
endmodule

// File: tb/spec_retire_buffer_test.sv
module spec_retire_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [1:0]  issue_class = 2'd0;
  logic [4:0]  issue_dest = '0;
  logic        issue_ready;
  logic [1:0]  issue_idx;
  logic        wb_valid = 1'b0;
  logic [1:0]  wb_idx = '0;
  logic [31:0] wb_data = '0;
  logic        done_valid = 1'b0;
  logic [1:0]  done_idx = '0;
  logic        done_misp = 1'b0;
  logic        ret_valid;
  logic [1:0]  ret_idx;
  logic [4:0]  ret_dest;
  logic [31:0] ret_value;
  logic [1:0]  ret_class;
  logic        flush;

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 0;

  // reference model state
  bit          m_valid [4];
  bit          m_rdy   [4];
  bit          m_misp  [4];
  logic [1:0]  m_cls   [4];
  logic [4:0]  m_dest  [4];
  logic [31:0] m_val   [4];
  logic [1:0]  m_head = 0, m_tail = 0;
  int          m_cnt = 0;

  spec_retire_buffer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .issue_valid_i(issue_valid), .issue_class_i(issue_class), .issue_dest_i(issue_dest),
    .issue_ready_o(issue_ready), .issue_idx_o(issue_idx),
    .wb_valid_i(wb_valid), .wb_idx_i(wb_idx), .wb_data_i(wb_data),
    .done_valid_i(done_valid), .done_idx_i(done_idx), .done_mispred_i(done_misp),
    .retire_valid_o(ret_valid), .retire_idx_o(ret_idx), .retire_dest_o(ret_dest),
    .retire_value_o(ret_value), .retire_class_o(ret_class), .flush_o(flush)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  function automatic bit exp_ret();
    return m_cnt > 0 && m_rdy[m_head];
  endfunction
  function automatic bit exp_flush();
    return exp_ret() && m_cls[m_head] == 2'd2 && m_misp[m_head];
  endfunction
  function automatic bit exp_ready();
    return (m_cnt < 4 || exp_ret()) && !exp_flush();
  endfunction

  // one cycle: drive at negedge, compare, advance model to the next edge
  task automatic step(bit iv, logic [1:0] ic, logic [4:0] id,
                      bit wv, logic [1:0] wi, logic [31:0] wd,
                      bit dv, logic [1:0] di, bit dm);
    bit r, f, rdy;
    @(negedge clk);
    issue_valid = iv; issue_class = ic; issue_dest = id;
    wb_valid = wv; wb_idx = wi; wb_data = wd;
    done_valid = dv; done_idx = di; done_misp = dm;
    #1;
    r = exp_ret(); f = exp_flush(); rdy = exp_ready();
    chk((m_cnt == 4 && r) ? "R7" : "R4", "issue_ready", 32'(issue_ready), 32'(rdy));
    chk("R1", "issue_idx", 32'(issue_idx), 32'(m_tail));
    chk("R3", "retire_valid", 32'(ret_valid), 32'(r));
    chk("R8", "flush", 32'(flush), 32'(f));
    if (r) begin
      chk("R2", "retire_idx", 32'(ret_idx), 32'(m_head));
      chk("R5", "retire_dest", 32'(ret_dest), 32'(m_dest[m_head]));
      chk(m_cls[m_head] == 2'd0 ? "R5" : "R9", "retire_value",
          ret_value, m_val[m_head]);
      chk("R6", "retire_class", 32'(ret_class), 32'(m_cls[m_head]));
    end
    // model update
    if (wv && m_valid[wi] && m_cls[wi] == 2'd0 && !m_rdy[wi]) begin
      m_val[wi] = wd; m_rdy[wi] = 1;
    end
    if (dv && m_valid[di] && m_cls[di] != 2'd0 && !m_rdy[di]) begin
      m_rdy[di] = 1; m_misp[di] = dm && m_cls[di] == 2'd2;
    end
    if (f) begin
      for (int k = 0; k < 4; k++) m_valid[k] = 0;
      m_head = m_head + 2'd1; m_tail = m_head; m_cnt = 0;
    end else begin
      if (r) begin m_valid[m_head] = 0; m_head = m_head + 2'd1; m_cnt--; end
      if (iv && rdy) begin
        m_valid[m_tail] = 1; m_rdy[m_tail] = 0; m_misp[m_tail] = 0;
        m_cls[m_tail] = ic; m_dest[m_tail] = id; m_val[m_tail] = '0;
        m_tail = m_tail + 2'd1; m_cnt++;
      end
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, MAX_CYCLES);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 4; k++) begin
      m_valid[k] = 0; m_rdy[k] = 0; m_misp[k] = 0;
      m_cls[k] = 0; m_dest[k] = 0; m_val[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "reset issue_ready", 32'(issue_ready), 32'd1);
    chk("R1", "reset retire_valid", 32'(ret_valid), 32'd0);
    chk("R1", "reset flush", 32'(flush), 32'd0);
    chk("R1", "reset issue_idx", 32'(issue_idx), 32'd0);

    // fill four ALU slots, then R4 stall
    for (int k = 0; k < 4; k++) step(1, 2'd0, 5'(k + 1), 0, 0, 0, 0, 0, 0);
    step(1, 2'd0, 5'd9, 0, 0, 0, 0, 0, 0);
    // R3: younger slot 1 completes first, must wait
    step(0, 0, 0, 1, 2'd1, 32'h11, 0, 0, 0);
    idle();
    // R5: slot 0 written, retires next cycle; R7: full issue accepted then
    step(0, 0, 0, 1, 2'd0, 32'h10, 0, 0, 0);
    step(1, 2'd0, 5'd5, 0, 0, 0, 0, 0, 0);
    idle();
    // R9: completion report to ALU slot 2 is ignored
    step(0, 0, 0, 0, 0, 0, 1, 2'd2, 0);
    idle();
    step(0, 0, 0, 1, 2'd2, 32'h22, 0, 0, 0);
    step(0, 0, 0, 1, 2'd3, 32'h33, 0, 0, 0);
    idle(); idle();
    step(0, 0, 0, 1, 2'd0, 32'h44, 0, 0, 0);
    idle();
    // R6/R8: store, mispredicted branch, younger ALU flushed
    step(1, 2'd1, 5'd6, 0, 0, 0, 0, 0, 0);
    step(1, 2'd2, 5'd7, 1, 2'd1, 32'hdead, 0, 0, 0);
    step(1, 2'd0, 5'd8, 0, 0, 0, 1, 2'd1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 2'd2, 1);
    step(0, 0, 0, 1, 2'd3, 32'h55, 0, 0, 0);
    idle(); idle();
    step(1, 2'd0, 5'd10, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 2'd0, 32'h66, 0, 0, 0);
    idle();

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 1) == 1, 2'($urandom_range(0, 2)), 5'($urandom),
           $urandom_range(0, 9) < 4, 2'($urandom), $urandom,
           $urandom_range(0, 9) < 3, 2'($urandom), $urandom_range(0, 7) == 0);
    end
    finish_run();
  end
endmodule